// File: doc/BRIEF.md
# Self-Restoring Serial Copy Between Two Shift Registers

This block moves one word from a source shift register to a destination shift register over a single serial wire. The source register takes a parallel code while the active-low load input is held low. After load returns high, a start pulse begins the transfer. On each clock the source sends out its top bit and rotates that same bit back into its bottom position. Over the same clocks the destination shifts toward its bottom bit and takes each arriving bit in at its top.

After exactly eight shift clocks the source holds its original code again, and the destination holds that code with its bit order reversed. The bit sent first lands in the destination's lowest position. A done flag then rises and stays high, and both registers hold, until the next load. The serial wire is brought out as a port, so the bit stream can be followed cycle by cycle. With the code 10110101 the wire carries 1,0,1,1,0,1,0,1, and the destination finishes at 10101101.

Top module: `xfer_top`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears srcQ, dstQ and done to zero, so linkBit reads 0 afterwards.
- R2: At a clock edge with loadN low (and rst low), srcQ takes parIn, dstQ clears to 0 and done clears to 0.
- R3: linkBit always shows srcQ bit 7, so the word leaves the source most significant bit first.
- R4: At every shift edge srcQ rotates left by one place: bit 7 re-enters at bit 0 and bit i moves to bit i+1. At any other edge with loadN high, srcQ holds.
- R5: At every shift edge dstQ shifts right by one place and the linkBit value from before the edge enters dstQ bit 7. At any other edge with loadN high, dstQ holds.
- R6: A transfer begins at an edge where start is high, loadN is high and the block is neither transferring nor done. Shifts then happen on exactly the next eight edges and no others.
- R7: When the transfer ends, done is 1, srcQ equals the loaded code and dstQ equals that code bit-reversed (dstQ bit i = code bit 7-i). For the code 10110101, dstQ is 10101101.
- R8: While done is 1 and loadN is high, done stays 1, srcQ and dstQ hold, and start is ignored.
- R9: start is ignored while a transfer is running: the transfer still ends after eight shifts with the result of R7.
- R10: Pulling loadN low during a transfer aborts it. The new code is captured, no further shifts occur, and a later start runs a complete fresh transfer.
- R11: If loadN is low at an edge, start is ignored at that edge. Load has priority, and no transfer begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both registers |
| rst | input | 1 | Synchronous reset, active high |
| loadN | input | 1 | Active-low parallel load of the source; also aborts a transfer |
| parIn | input | 8 | Parallel code for the source register |
| start | input | 1 | Begins a transfer when the block is idle and load is inactive |
| linkBit | output | 1 | Serial bit on the wire between the registers (source bit 7) |
| srcQ | output | 8 | Source register contents |
| dstQ | output | 8 | Destination register contents |
| done | output | 1 | High once eight shifts have completed, until the next load or reset |

## Verification
The main transfer is run with the asymmetric code 10110101, where the wire sequence and the final 10101101 show the bit order, the entry end and the reversal together. It is also run with a lone high bit (10000000 and 00000001), which exposes any swap between rotate direction and entry position, and a mistaken shift count. The patterns all ones, all zeros and 11000110 check that the feedback path neither loses nor invents bits. They also check that a code which equals its own reverse does not hide a fault. Start held high throughout, a load part-way through, and start applied together with load check that the control counts exactly eight shifts and obeys load priority.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  // Strobes issued by the sequencer to the register datapath
  typedef struct packed {
    logic load;   // capture parallel code, clear destination
    logic shift;  // rotate source, shift destination
  } xferStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } xferState_t;

endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        loadN,
  input  logic        start,
  output xferStrobe_t strb,
  output logic        done
);

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  xferState_t       state, stateNext;
  logic [CNT_W-1:0] shiftCnt, shiftCntNext;

  always_comb begin
    stateNext    = state;
    shiftCntNext = shiftCnt;
    strb.load    = 1'b0;
    strb.shift   = 1'b0;
    if (!loadN) begin
      // load has priority over everything and restarts the sequence
      strb.load    = 1'b1;
      stateNext    = ST_IDLE;
      shiftCntNext = '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            stateNext    = ST_RUN;
            shiftCntNext = '0;
          end
        end
        ST_RUN: begin
          strb.shift   = 1'b1;
          shiftCntNext = shiftCnt + 1'b1;
          if (shiftCnt == LAST) begin
            stateNext    = ST_DONE;
            shiftCntNext = '0;
          end
        end
        ST_DONE: begin
          stateNext = ST_DONE;
        end
        default: begin
          stateNext = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      shiftCnt <= '0;
    end else begin
      state    <= stateNext;
      shiftCnt <= shiftCntNext;
    end
  end

  assign done = (state == ST_DONE);

endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  xferStrobe_t      strb,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] srcQ,
  output logic [WIDTH-1:0] dstQ,
  output logic             linkBit
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] srcReg, dstReg;
  logic [WIDTH-1:0] srcNext, dstNext;

  // serial wire: source MSB leaves first
  assign linkBit = srcReg[TOP];

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      // source: rotate left, the outgoing MSB re-enters at bit 0
      if (i == 0) begin : g_srcLow
        always_comb begin
          if (strb.load)       srcNext[i] = parIn[i];
          else if (strb.shift) srcNext[i] = srcReg[TOP];
          else                 srcNext[i] = srcReg[i];
        end
      end else begin : g_srcUp
        always_comb begin
          if (strb.load)       srcNext[i] = parIn[i];
          else if (strb.shift) srcNext[i] = srcReg[i-1];
          else                 srcNext[i] = srcReg[i];
        end
      end

      // destination: shift right, the serial bit enters at the top
      if (i == TOP) begin : g_dstTop
        always_comb begin
          if (strb.load)       dstNext[i] = 1'b0;
          else if (strb.shift) dstNext[i] = linkBit;
          else                 dstNext[i] = dstReg[i];
        end
      end else begin : g_dstLow
        always_comb begin
          if (strb.load)       dstNext[i] = 1'b0;
          else if (strb.shift) dstNext[i] = dstReg[i+1];
          else                 dstNext[i] = dstReg[i];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      srcReg <= '0;
      dstReg <= '0;
    end else begin
      srcReg <= srcNext;
      dstReg <= dstNext;
    end
  end

  assign srcQ = srcReg;
  assign dstQ = dstReg;

endmodule

// File: rtl/xfer_top.sv
module xfer_top
  import xfer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadN,
  input  logic [WIDTH-1:0] parIn,
  input  logic             start,
  output logic             linkBit,
  output logic [WIDTH-1:0] srcQ,
  output logic [WIDTH-1:0] dstQ,
  output logic             done
);

  xferStrobe_t strb;

  xfer_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .loadN (loadN),
    .start (start),
    .strb  (strb),
    .done  (done)
  );

  xfer_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .parIn   (parIn),
    .srcQ    (srcQ),
    .dstQ    (dstQ),
    .linkBit (linkBit)
  );

endmodule

// File: rtl/xfer_chk.sv
module xfer_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             loadN,
  input logic [WIDTH-1:0] parIn,
  input logic             start,
  input logic             linkBit,
  input logic [WIDTH-1:0] srcQ,
  input logic [WIDTH-1:0] dstQ,
  input logic             done
);

  function automatic logic [WIDTH-1:0] revBits(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int k = 0; k < WIDTH; k++) r[k] = v[WIDTH-1-k];
    return r;
  endfunction

  // R1: reset clears the registers and done
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (srcQ == '0 && dstQ == '0 && !done));

  // R2: load captures the parallel code and clears the destination
  p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
    !loadN |=> (srcQ == $past(parIn) && dstQ == '0 && !done));

  // R4: the source only holds or rotates left
  p_src_rotate_r4: assert property (@(posedge clk) disable iff (rst)
    loadN |=> ($stable(srcQ) ||
               srcQ == {$past(srcQ[WIDTH-2:0]), $past(srcQ[WIDTH-1])}));

  // R5: the destination only holds or shifts right with the link bit on top
  p_dst_entry_r5: assert property (@(posedge clk) disable iff (rst)
    loadN |=> ($stable(dstQ) ||
               dstQ == {$past(linkBit), $past(dstQ[WIDTH-1:1])}));

  // R7: at completion the destination is the bit-reverse of the source
  p_done_result_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (dstQ == revBits(srcQ)));

  // R8: done holds and freezes both registers until the next load
  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done && loadN) |=> (done && $stable(srcQ) && $stable(dstQ)));

  // R3: the serial wire mirrors the source MSB (immediate check)
  always_comb begin
    if (!rst) begin
      a_link_msb_r3: assert (linkBit == srcQ[WIDTH-1]);
    end
  end

endmodule

bind xfer_top xfer_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_xfer_top.sv
`timescale 1ns/1ps
module sim_xfer_top;

  localparam int W = 8;
  localparam time HALF = 2.5ns;
  localparam int LIMIT_CYCLES = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         loadN = 1'b1;
  logic [W-1:0] parIn = '0;
  logic         start = 1'b0;
  logic         linkBit;
  logic [W-1:0] srcQ, dstQ;
  logic         done;

  int nChecks = 0;
  int nFails  = 0;

  always #(HALF) clk = ~clk;

  xfer_top #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .loadN(loadN), .parIn(parIn), .start(start),
    .linkBit(linkBit), .srcQ(srcQ), .dstQ(dstQ), .done(done)
  );

  function automatic logic [W-1:0] rev8(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) r[k] = v[W-1-k];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doLoad(input logic [W-1:0] code);
    @(negedge clk);
    loadN = 1'b0; parIn = code; start = 1'b0;
    @(negedge clk);
    loadN = 1'b1;
    chk(srcQ == code, "R2 src", srcQ, code);
    chk(dstQ == '0,   "R2 dst", dstQ, '0);
    chk(done == 1'b0, "R2 done", {7'd0, done}, '0);
  endtask

  // start at this negedge, then follow the eight shifts
  task automatic runXfer(input logic [W-1:0] code, input bit holdStart);
    start = 1'b1;
    @(negedge clk);               // past the start edge, no shift yet
    if (!holdStart) start = 1'b0;
    for (int i = 0; i < W; i++) begin
      chk(linkBit == code[W-1-i], "R3 link", {7'd0, linkBit}, {7'd0, code[W-1-i]});
      chk(done == 1'b0, "R6 early done", {7'd0, done}, '0);
      @(negedge clk);
    end
    chk(done == 1'b1, "R6 done after 8", {7'd0, done}, 8'd1);
    chk(srcQ == code, "R4 R7 src restored", srcQ, code);
    chk(dstQ == rev8(code), "R5 R7 dst reversed", dstQ, rev8(code));
    start = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(srcQ == '0, "R1 src", srcQ, '0);
    chk(dstQ == '0, "R1 dst", dstQ, '0);
    chk(done == 1'b0 && linkBit == 1'b0, "R1 done/link", {6'd0, done, linkBit}, '0);
    rst = 1'b0;
  endtask

  task automatic t_basic();
    doLoad(8'b10110101);
    runXfer(8'b10110101, 1'b0);
    chk(dstQ == 8'b10101101, "R7 literal", dstQ, 8'b10101101);
  endtask

  task automatic t_patterns();
    logic [W-1:0] pats [6] = '{8'h80, 8'h01, 8'hFF, 8'h00, 8'hC6, 8'h3C};
    foreach (pats[k]) begin
      doLoad(pats[k]);
      runXfer(pats[k], 1'b0);
    end
  endtask

  task automatic t_holdStart();
    // R9: start held high through the whole transfer; R8: held after done
    doLoad(8'b01101001);
    runXfer(8'b01101001, 1'b1);
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R8 done held", {7'd0, done}, 8'd1);
    chk(srcQ == 8'b01101001, "R8 src held", srcQ, 8'b01101001);
    chk(dstQ == 8'b10010110, "R8 dst held", dstQ, 8'b10010110);
  endtask

  task automatic t_abort();
    doLoad(8'b10110101);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);    // three shifts done
    doLoad(8'b11100010);          // R10: abort with new code
    repeat (3) @(negedge clk);
    chk(srcQ == 8'b11100010, "R10 no shift after abort", srcQ, 8'b11100010);
    chk(dstQ == '0, "R10 dst idle", dstQ, '0);
    runXfer(8'b11100010, 1'b0);
  endtask

  task automatic t_loadPriority();
    @(negedge clk);
    loadN = 1'b0; parIn = 8'b10010011; start = 1'b1;
    @(negedge clk);
    loadN = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    chk(srcQ == 8'b10010011, "R11 start ignored under load", srcQ, 8'b10010011);
    chk(dstQ == '0 && done == 1'b0, "R11 no transfer", dstQ, '0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_patterns();
    t_holdStart();
    t_abort();
    t_loadPriority();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (LIMIT_CYCLES) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule